// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is a single timer channel configured for measurement. A free-running counter advances on each qualified tick. Selected transitions on input pin A copy the counter into two capture registers, first A-capture and then B-capture. Software reads the two captured values and takes the difference to get a pulse width or a period.

A trigger returns the counter to zero and restarts the capture sequence. The trigger can come from a software strobe, from a selected edge on pin A or pin B, or from a match between the counter and a compare value. A B-capture may optionally freeze the counter or switch its clock off. Sticky status flags record:
- overflow;
- capture overrun;
- each of the two loads;
- the compare match;
- an external trigger.

A single read strobe clears all of the flags.

Top module: `cap_timer_chan`

## Requirements
- R1: After a synchronous reset the counter, both capture registers and all six flags are zero, and the clock-on status `clk_on` is low.
- R2: While `clk_on` is high and the channel is not frozen, the counter rises by one on each cycle with `tick_en` high. It holds while `tick_en` is low or `clk_on` is low. `cmd_en` sets `clk_on` and `cmd_dis` clears it, and `cmd_dis` wins when both are asserted in the same cycle.
- R3: `mode_word[1:0]` selects the A-capture edge on pin A: 0 none, 1 rising, 2 falling, 3 both. A selected edge stores the counter into `ra_val` and sets flag bit 2. With code 0, pin A never loads `ra_val`.
- R4: `mode_word[3:2]` selects the B-capture edge on pin A, using the same encoding. `rb_val` loads only after an A-capture since the last trigger or the last B-capture. After a B-capture, the next qualifying edge goes to A-capture again. A B-capture sets flag bit 3.
- R5: Flag bit 1 (overrun) sets when a capture register is loaded while its loaded flag is still set and no read strobe is present in that cycle.
- R6: With `mode_word[8]` set, a B-capture freezes the counter while `clk_on` stays high. A trigger or `cmd_en` releases the freeze.
- R7: With `mode_word[9]` set, a B-capture clears `clk_on`. Counting then resumes only after `cmd_en`.
- R8: `mode_word[5:4]` selects the external trigger edge, using the same encoding as R3. `mode_word[6]` picks the source pin: 0 for pin A, 1 for pin B. An external trigger zeroes the counter, re-arms A-capture and sets flag bit 5. Edges on the pin that is not selected have no effect.
- R9: A `cmd_swtrg` pulse zeroes the counter on the next clock edge and re-arms A-capture.
- R10: A counting tick while the counter equals `rc_val` sets flag bit 4. With `mode_word[7]` set, that same tick returns the counter to zero instead of incrementing it.
- R11: A counting tick at the all-ones counter value wraps the counter to zero and sets flag bit 0.
- R12: `sts_rd` clears all six flags. An event in the same cycle still sets its flag.
- R13: Pins pass through a two-flop synchronizer. A capture register shows its new value after the third rising clock edge following a pin change, holding the counter value of the detection cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick qualifier |
| cmd_en | input | 1 | Clock-on command strobe |
| cmd_dis | input | 1 | Clock-off command strobe |
| cmd_swtrg | input | 1 | Software trigger strobe |
| sts_rd | input | 1 | Flag read-and-clear strobe |
| mode_word | input | 10 | Channel mode fields (see R3 to R10) |
| pin_a | input | 1 | Measured input, capture and trigger source |
| pin_b | input | 1 | Alternate trigger source |
| rc_val | input | CNT_W | Compare value |
| cnt_val | output | CNT_W | Counter value |
| ra_val | output | CNT_W | A-capture register |
| rb_val | output | CNT_W | B-capture register |
| flags | output | 6 | Sticky status: 0 overflow, 1 overrun, 2 A loaded, 3 B loaded, 4 compare, 5 external trigger |
| clk_on | output | 1 | Counter clock enabled status |

## Verification
The capture path is tried with four pin-A patterns, and they separate different properties:
- A single rising or falling transition checks edge selection and synchronizer latency.
- Two same-direction rises with one fall between them check that the A/B ordering alternates.
- A both-edge train left unread checks overrun.
- Edges with the edge code at none check that an unselected edge is ignored.

The trigger is driven from pin A, pin B, software strobes and compare matches. Edges are placed on the unselected pin and in the unselected direction, which separates source selection from edge selection. The freeze and disable options are run back to back so that a counter held frozen with `clk_on` high can be told apart from a clock that has been switched off.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam int MODE_W  = 10;
  localparam int N_FLAGS = 6;

  localparam int FLG_OVF = 0;
  localparam int FLG_OVR = 1;
  localparam int FLG_LDA = 2;
  localparam int FLG_LDB = 3;
  localparam int FLG_RC  = 4;
  localparam int FLG_EXT = 5;

  typedef struct packed {
    logic      dis_on_b;
    logic      stop_on_b;
    logic      rc_trig;
    logic      trig_src_b;
    edge_sel_e trig_edge;
    edge_sel_e b_edge;
    edge_sel_e a_edge;
  } mode_t;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      2'd1:    edge_hit = rise;
      2'd2:    edge_hit = fall;
      2'd3:    edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int N_PINS = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] rise,
  output logic [N_PINS-1:0] fall
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], pin_in[i]};
    end
    assign rise[i] =  chain[STAGES-1] & ~chain[STAGES];
    assign fall[i] = ~chain[STAGES-1] &  chain[STAGES];
  end

endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             clr,
  input  logic             stop_evt,
  input  logic             dis_evt,
  input  logic [CNT_W-1:0] rc_val,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_on,
  output logic             ovf_evt,
  output logic             rc_evt
);

  logic frozen;
  logic counting;

  assign counting = clk_on & ~frozen & tick_en;
  assign rc_evt   = counting & (cnt == rc_val);
  assign ovf_evt  = counting & (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_on <= 1'b0;
    end else if (cmd_dis || dis_evt) begin
      clk_on <= 1'b0;
    end else if (cmd_en) begin
      clk_on <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen <= 1'b0;
    end else if (clr || cmd_en) begin
      frozen <= 1'b0;
    end else if (stop_evt) begin
      frozen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (counting) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cap_capture.sv
module cap_capture
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_hit,
  input  logic               b_hit,
  input  logic               rearm,
  input  logic               sts_rd,
  input  logic               ovf_evt,
  input  logic               rc_evt,
  input  logic               ext_evt,
  input  logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   ra,
  output logic [CNT_W-1:0]   rb,
  output logic [N_FLAGS-1:0] flags,
  output logic               ld_a,
  output logic               ld_b
);

  logic               arm_b;
  logic [N_FLAGS-1:0] flags_nxt;
  logic               overrun;

  assign ld_a    = a_hit & ~arm_b;
  assign ld_b    = b_hit &  arm_b;
  assign overrun = ~sts_rd & ((ld_a & flags[FLG_LDA]) | (ld_b & flags[FLG_LDB]));

  always_comb begin
    flags_nxt = sts_rd ? '0 : flags;
    if (ovf_evt) flags_nxt[FLG_OVF] = 1'b1;
    if (overrun) flags_nxt[FLG_OVR] = 1'b1;
    if (ld_a)    flags_nxt[FLG_LDA] = 1'b1;
    if (ld_b)    flags_nxt[FLG_LDB] = 1'b1;
    if (rc_evt)  flags_nxt[FLG_RC]  = 1'b1;
    if (ext_evt) flags_nxt[FLG_EXT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_b <= 1'b0;
    end else if (rearm) begin
      arm_b <= 1'b0;
    end else if (ld_a) begin
      arm_b <= 1'b1;
    end else if (ld_b) begin
      arm_b <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra    <= '0;
      rb    <= '0;
      flags <= '0;
    end else begin
      if (ld_a) ra <= cnt;
      if (ld_b) rb <= cnt;
      flags <= flags_nxt;
    end
  end

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               cmd_en,
  input  logic               cmd_dis,
  input  logic               cmd_swtrg,
  input  logic               sts_rd,
  input  logic [MODE_W-1:0]  mode_word,
  input  logic               pin_a,
  input  logic               pin_b,
  input  logic [CNT_W-1:0]   rc_val,
  output logic [CNT_W-1:0]   cnt_val,
  output logic [CNT_W-1:0]   ra_val,
  output logic [CNT_W-1:0]   rb_val,
  output logic [N_FLAGS-1:0] flags,
  output logic               clk_on
);

  localparam int PIN_A = 0;
  localparam int PIN_B = 1;

  mode_t      m;
  logic [1:0] p_rise;
  logic [1:0] p_fall;
  logic       a_hit;
  logic       b_hit;
  logic       ext_evt;
  logic       trig_any;
  logic       ld_a;
  logic       ld_b;
  logic       ovf_evt;
  logic       rc_evt;

  assign m = mode_t'(mode_word);

  cap_sync_edge #(
    .N_PINS (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in ({pin_b, pin_a}),
    .rise   (p_rise),
    .fall   (p_fall)
  );

  assign a_hit   = edge_hit(m.a_edge, p_rise[PIN_A], p_fall[PIN_A]);
  assign b_hit   = edge_hit(m.b_edge, p_rise[PIN_A], p_fall[PIN_A]);
  assign ext_evt = m.trig_src_b ? edge_hit(m.trig_edge, p_rise[PIN_B], p_fall[PIN_B])
                                : edge_hit(m.trig_edge, p_rise[PIN_A], p_fall[PIN_A]);
  assign trig_any = cmd_swtrg | ext_evt | (m.rc_trig & rc_evt);

  cap_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .cmd_en   (cmd_en),
    .cmd_dis  (cmd_dis),
    .clr      (trig_any),
    .stop_evt (ld_b & m.stop_on_b),
    .dis_evt  (ld_b & m.dis_on_b),
    .rc_val   (rc_val),
    .cnt      (cnt_val),
    .clk_on   (clk_on),
    .ovf_evt  (ovf_evt),
    .rc_evt   (rc_evt)
  );

  cap_capture #(
    .CNT_W (CNT_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .a_hit   (a_hit),
    .b_hit   (b_hit),
    .rearm   (trig_any),
    .sts_rd  (sts_rd),
    .ovf_evt (ovf_evt),
    .rc_evt  (rc_evt),
    .ext_evt (ext_evt),
    .cnt     (cnt_val),
    .ra      (ra_val),
    .rb      (rb_val),
    .flags   (flags),
    .ld_a    (ld_a),
    .ld_b    (ld_b)
  );

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             sts_rd,
  input logic             cmd_dis,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] ra_val,
  input logic [5:0]       flags,
  input logic             clk_on,
  input logic             trig_any,
  input logic             ld_a,
  input logic             ld_b,
  input logic             ext_evt,
  input logic             dis_on_b,
  input logic             ovf_evt,
  input logic             rc_evt
);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !trig_any) |=> (cnt_val == $past(cnt_val)));

  // R9
  trig_zero_chk: assert property (@(posedge clk) disable iff (rst)
    trig_any |=> (cnt_val == '0));

  // R3
  ra_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(ra_val));

  // R4
  ab_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ld_a |-> !ld_b);

  // R7
  clk_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_on) |-> ($past(cmd_dis) || $past(ld_b && dis_on_b)));

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_rd && !ld_a && !ld_b && !ext_evt && !ovf_evt && !rc_evt) |=> (flags == 6'd0));

endmodule

bind cap_timer_chan cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .sts_rd   (sts_rd),
  .cmd_dis  (cmd_dis),
  .cnt_val  (cnt_val),
  .ra_val   (ra_val),
  .flags    (flags),
  .clk_on   (clk_on),
  .trig_any (trig_any),
  .ld_a     (ld_a),
  .ld_b     (ld_b),
  .ext_evt  (ext_evt),
  .dis_on_b (m.dis_on_b),
  .ovf_evt  (ovf_evt),
  .rc_evt   (rc_evt)
);

// File: tb/test_cap_timer_chan.sv
module test_cap_timer_chan;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         cmd_en = 1'b0;
  logic         cmd_dis = 1'b0;
  logic         cmd_swtrg = 1'b0;
  logic         sts_rd = 1'b0;
  logic [9:0]   mode_word = '0;
  logic         pin_a = 1'b0;
  logic         pin_b = 1'b0;
  logic [W-1:0] rc_val = 8'd200;
  logic [W-1:0] cnt_val;
  logic [W-1:0] ra_val;
  logic [W-1:0] rb_val;
  logic [5:0]   flags;
  logic         clk_on;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cap_timer_chan #(.CNT_W(W), .SYNC_STAGES(2)) i_cap_timer_chan (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cmd_en    (cmd_en),
    .cmd_dis   (cmd_dis),
    .cmd_swtrg (cmd_swtrg),
    .sts_rd    (sts_rd),
    .mode_word (mode_word),
    .pin_a     (pin_a),
    .pin_b     (pin_b),
    .rc_val    (rc_val),
    .cnt_val   (cnt_val),
    .ra_val    (ra_val),
    .rb_val    (rb_val),
    .flags     (flags),
    .clk_on    (clk_on)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en();
    cmd_en = 1'b1; nc(1); cmd_en = 1'b0;
  endtask

  task automatic swtrg();
    cmd_swtrg = 1'b1; nc(1); cmd_swtrg = 1'b0;
  endtask

  task automatic read_clr();
    sts_rd = 1'b1; nc(1); sts_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1; nc(n); tick_en = 1'b0;
  endtask

  task automatic set_a(input logic v);
    pin_a = v; nc(4);
  endtask

  task automatic set_b(input logic v);
    pin_b = v; nc(4);
  endtask

  task automatic t_reset();
    check("R1 cnt", cnt_val, 0);
    check("R1 ra", ra_val, 0);
    check("R1 rb", rb_val, 0);
    check("R1 flags", flags, 0);
    check("R1 clk_on", clk_on, 0);
  endtask

  task automatic t_count();
    pulse_en();
    check("R2 enable", clk_on, 1);
    ticks(5);
    check("R2 count", cnt_val, 5);
    nc(3);
    check("R2 hold no tick", cnt_val, 5);
    cmd_en = 1'b1; cmd_dis = 1'b1; nc(1); cmd_en = 1'b0; cmd_dis = 1'b0;
    check("R2 dis wins", clk_on, 0);
    ticks(3);
    check("R2 hold disabled", cnt_val, 5);
    pulse_en();
  endtask

  task automatic t_capture();
    mode_word = 10'h009;
    swtrg();
    check("R9 swtrg zero", cnt_val, 0);
    ticks(7);
    pin_a = 1'b1; nc(2);
    check("R13 not yet", ra_val, 0);
    nc(1);
    check("R13 latency", ra_val, 7);
    nc(1);
    check("R3 flag", flags, 6'b000100);
    ticks(4);
    set_a(1'b0);
    check("R4 rb value", rb_val, 11);
    check("R4 flag", flags, 6'b001100);
  endtask

  task automatic t_order();
    read_clr();
    mode_word = 10'h005;
    swtrg();
    ticks(2);
    set_a(1'b1);
    check("R4 first goes to ra", ra_val, 2);
    check("R4 rb untouched", rb_val, 11);
    check("R4 flags after ra", flags, 6'b000100);
    set_a(1'b0);
    ticks(3);
    set_a(1'b1);
    check("R4 second goes to rb", rb_val, 5);
    check("R4 ra kept", ra_val, 2);
    read_clr();
    mode_word = 10'h000;
    swtrg();
    set_a(1'b0);
    set_a(1'b1);
    check("R3 none ignored ra", ra_val, 2);
    check("R3 none ignored flags", flags, 0);
  endtask

  task automatic t_overrun();
    read_clr();
    mode_word = 10'h00F;
    swtrg();
    ticks(1);
    set_a(1'b0);
    check("R5 ra load", ra_val, 1);
    ticks(1);
    set_a(1'b1);
    check("R5 rb load", rb_val, 2);
    check("R5 no overrun yet", flags[1], 0);
    ticks(1);
    set_a(1'b0);
    check("R5 ra reload", ra_val, 3);
    check("R5 overrun", flags, 6'b001110);
    read_clr();
    check("R12 read clears", flags, 0);
  endtask

  task automatic t_stop();
    mode_word = 10'h109;
    read_clr();
    swtrg();
    ticks(2);
    set_a(1'b1);
    ticks(2);
    set_a(1'b0);
    check("R6 rb value", rb_val, 4);
    ticks(5);
    check("R6 frozen", cnt_val, 4);
    check("R6 clk stays on", clk_on, 1);
    swtrg();
    ticks(3);
    check("R6 resume after trigger", cnt_val, 3);
  endtask

  task automatic t_disable();
    mode_word = 10'h209;
    swtrg();
    set_a(1'b1);
    ticks(1);
    set_a(1'b0);
    check("R7 rb value", rb_val, 1);
    check("R7 clk off", clk_on, 0);
    ticks(3);
    check("R7 no count", cnt_val, 1);
    pulse_en();
    ticks(2);
    check("R7 re-enabled", cnt_val, 3);
  endtask

  task automatic t_ext_trig();
    read_clr();
    mode_word = 10'h050;
    ticks(6);
    check("R8 pre count", cnt_val, 9);
    pin_b = 1'b1; nc(2);
    check("R8 not yet", cnt_val, 9);
    nc(1);
    check("R8 b rising zeroes", cnt_val, 0);
    check("R8 ext flag", flags[5], 1);
    nc(1);
    mode_word = 10'h010;
    ticks(4);
    set_b(1'b0);
    set_b(1'b1);
    check("R8 unselected pin ignored", cnt_val, 4);
    set_a(1'b1);
    check("R8 a rising zeroes", cnt_val, 0);
    mode_word = 10'h020;
    ticks(2);
    set_a(1'b0);
    check("R8 a falling zeroes", cnt_val, 0);
    ticks(2);
    set_a(1'b1);
    check("R8 wrong direction ignored", cnt_val, 2);
  endtask

  task automatic t_compare();
    mode_word = 10'h080;
    rc_val = 8'd4;
    swtrg();
    read_clr();
    ticks(4);
    check("R10 at rc", cnt_val, 4);
    check("R10 no flag yet", flags[4], 0);
    ticks(1);
    check("R10 wrap to zero", cnt_val, 0);
    check("R10 flag", flags[4], 1);
    mode_word = 10'h000;
    read_clr();
    swtrg();
    ticks(6);
    check("R10 no retrigger", cnt_val, 6);
    check("R10 flag no retrigger", flags[4], 1);
    rc_val = 8'd200;
  endtask

  task automatic t_overflow();
    read_clr();
    swtrg();
    ticks(255);
    check("R11 max", cnt_val, 255);
    check("R11 no flag yet", flags[0], 0);
    ticks(1);
    check("R11 wrap", cnt_val, 0);
    check("R11 flag", flags[0], 1);
  endtask

  initial begin
    nc(3);
    rst = 1'b0;
    nc(1);
    t_reset();
    t_count();
    t_capture();
    t_order();
    t_overrun();
    t_stop();
    t_disable();
    t_ext_trig();
    t_compare();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule